// File: doc/BRIEF.md
# Context-Banked Register Window with Shadowed Instruction Pointer and Status

The block holds the architectural register state for many hardware contexts. Storage has 32 banks of 16 registers each. Only one bank is visible at a time, as a 16-entry window. Two combinational read ports and one write port address that window. Changing the visible bank is a single-cycle context switch: the whole register set swaps at once, including the instruction pointer and the status word.

Window index 0 is the instruction pointer and index 1 is the status word. Every pipeline cycle needs them, and the bank has too few ports to serve them. So each has a working copy in dedicated flip-flops, with its own path from the fetch stage and its own output pins. The bank's own copy of these two slots is touched in only two cases:
- a register-port write to index 0 or 1;
- a bank switch, which stores the working copies into the outgoing bank and loads them from the incoming bank in the same edge.

A read of index 0 therefore always gives the live next-fetch address, which code can use for position-independent address arithmetic.

Top module: `ctx_regfile`

## Requirements
- R1: After reset, `ctx_bank` is 0 and `ip_out` and `status_out` are 0.
- R2: A read of index 2..15 on either read port returns the value most recently written to that index of the visible bank. A write with `wr_en` takes effect at the next rising edge.
- R3: A read of index 0 returns `ip_out` and a read of index 1 returns `status_out`, never the bank's copy.
- R4: With `fetch_vld` high and no port write to index 0, `ip_out` takes `fetch_ip` after the edge.
- R5: A port write to index 0 (or 1) sets `ip_out` (or `status_out`) to `wr_data` after the edge, even if `fetch_vld` is high in the same cycle. It also writes the bank copy.
- R6: When `ctx_swap` is high, `ctx_bank` takes `ctx_sel` after the edge. Otherwise `ctx_bank` holds its value.
- R7: On a swap, the outgoing bank's slots 0 and 1 receive the working values as updated in that same cycle (port write, else fetch update, else hold). Swapping back later restores them.
- R8: On a swap to a different bank, `ip_out` and `status_out` take that bank's stored slot 0 and slot 1 values after the edge.
- R9: On a swap to the bank already visible, `ip_out` and `status_out` keep their same-cycle updated values.
- R10: A port write in a swap cycle lands in the outgoing bank, not the incoming one.
- R11: `status_out` changes only through a port write to index 1 or a swap. `fetch_vld` never alters it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_idx | input | 4 | Read port 0 window index |
| rd1_idx | input | 4 | Read port 1 window index |
| rd0_data | output | 32 | Read port 0 data (combinational) |
| rd1_data | output | 32 | Read port 1 data (combinational) |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port window index |
| wr_data | input | 32 | Write port data |
| fetch_vld | input | 1 | Fetch stage presents a new instruction pointer |
| fetch_ip | input | 32 | Next instruction pointer from fetch |
| ctx_swap | input | 1 | Bank switch strobe |
| ctx_sel | input | 5 | Bank to make visible on a switch |
| ctx_bank | output | 5 | Currently visible bank |
| ip_out | output | 32 | Working instruction pointer |
| status_out | output | 32 | Working status word |

## Verification
The bench aims at the cycle where a swap meets a same-cycle update. A design that saved the pre-update working value would lose a fetch or port write on return to the bank (R7). One that reloaded stale storage on a same-bank swap would roll the IP back (R9). A port write during a swap that landed in the incoming bank would corrupt a context never addressed (R10). Random mixes of port writes and fetch updates in one cycle catch a reversed priority. Reads of indices 0 and 1 right after a fetch update catch a design that serves the stale bank copy.

// File: rtl/ctxrf_pkg.sv
package ctxrf_pkg;

  // Source selected for a working (shadow) register on a given edge.
  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_FETCH = 2'd1,
    SRC_PORT  = 2'd2,
    SRC_BANK  = 2'd3
  } shsrc_e;

  // Priority of same-cycle updates before a possible bank reload.
  function automatic shsrc_e merge_src(input logic port_hit, input logic fetch_hit);
    if (port_hit)       return SRC_PORT;
    else if (fetch_hit) return SRC_FETCH;
    else                return SRC_HOLD;
  endfunction

  // Final source after a swap is considered.
  function automatic shsrc_e final_src(input shsrc_e merged, input logic reload);
    return reload ? SRC_BANK : merged;
  endfunction

endpackage

// File: rtl/ctxrf_bank_ctl.sv
module ctxrf_bank_ctl #(
  parameter int NBANK = 32,
  localparam int BW = $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swap,
  input  logic [BW-1:0] sel,
  output logic [BW-1:0] cur,
  output logic          reload
);

  always_ff @(posedge clk) begin
    if (!rst_n)    cur <= '0;
    else if (swap) cur <= sel;
  end

  // A swap that changes bank must reload the working copies from storage.
  assign reload = swap && (sel != cur);

  a_r6_switch_takes_sel: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> cur == $past(sel));
  a_r6_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |=> $stable(cur));

endmodule

// File: rtl/ctxrf_shadow.sv
module ctxrf_shadow
  import ctxrf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ip_port_hit,
  input  logic          st_port_hit,
  input  logic [DW-1:0] port_data,
  input  logic          fetch_vld,
  input  logic [DW-1:0] fetch_ip,
  input  logic          swap,
  input  logic          reload,
  input  logic [DW-1:0] load_ip,
  input  logic [DW-1:0] load_st,
  output logic [DW-1:0] ip_q,
  output logic [DW-1:0] st_q,
  output logic [DW-1:0] ip_merged,
  output logic [DW-1:0] st_merged
);

  shsrc_e ip_mrg_src, st_mrg_src, ip_src, st_src;
  logic [DW-1:0] ip_d, st_d;

  always_comb begin
    ip_mrg_src = merge_src(ip_port_hit, fetch_vld);
    st_mrg_src = merge_src(st_port_hit, 1'b0);
    ip_src     = final_src(ip_mrg_src, reload);
    st_src     = final_src(st_mrg_src, reload);

    unique case (ip_mrg_src)
      SRC_PORT:  ip_merged = port_data;
      SRC_FETCH: ip_merged = fetch_ip;
      default:   ip_merged = ip_q;
    endcase
    unique case (st_mrg_src)
      SRC_PORT:  st_merged = port_data;
      default:   st_merged = st_q;
    endcase

    ip_d = (ip_src == SRC_BANK) ? load_ip : ip_merged;
    st_d = (st_src == SRC_BANK) ? load_st : st_merged;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ip_q <= '0;
      st_q <= '0;
    end else begin
      ip_q <= ip_d;
      st_q <= st_d;
    end
  end

  // R5: port write beats fetch.
  a_r5_port_wins_ip: assert property (@(posedge clk) disable iff (!rst_n)
    ip_port_hit && !reload |=> ip_q == $past(port_data));
  a_r4_fetch_loads_ip: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld && !ip_port_hit && !reload |=> ip_q == $past(fetch_ip));
  a_r8_reload_from_bank: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> ip_q == $past(load_ip) && st_q == $past(load_st));
  a_r9_same_bank_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    swap && !reload && !ip_port_hit && !fetch_vld |=> $stable(ip_q));
  a_r11_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !st_port_hit && !swap |=> $stable(st_q));

endmodule

// File: rtl/ctxrf_store.sv
module ctxrf_store #(
  parameter int NBANK = 32,
  parameter int NREG  = 16,
  parameter int DW    = 32,
  localparam int BW = $clog2(NBANK),
  localparam int IW = $clog2(NREG),
  localparam int AW = BW + IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] cur,
  input  logic [BW-1:0] next_bank,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          save,
  input  logic [DW-1:0] save_ip,
  input  logic [DW-1:0] save_st,
  input  logic [IW-1:0] rd0_idx,
  input  logic [IW-1:0] rd1_idx,
  output logic [DW-1:0] rd0_raw,
  output logic [DW-1:0] rd1_raw,
  output logic [DW-1:0] load_ip,
  output logic [DW-1:0] load_st
);

  localparam logic [IW-1:0] SLOT_IP = IW'(0);
  localparam logic [IW-1:0] SLOT_ST = IW'(1);

  logic [DW-1:0] mem [NBANK*NREG];

  logic [AW-1:0] wr_addr, sv_ip_addr, sv_st_addr;
  assign wr_addr    = {cur, wr_idx};
  assign sv_ip_addr = {cur, SLOT_IP};
  assign sv_st_addr = {cur, SLOT_ST};

  // Save writes follow the port write, so on a collision the merged
  // working value (which already contains the port data) is stored.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (save) begin
      mem[sv_ip_addr] <= save_ip;
      mem[sv_st_addr] <= save_st;
    end
  end

  assign rd0_raw = mem[{cur, rd0_idx}];
  assign rd1_raw = mem[{cur, rd1_idx}];
  assign load_ip = mem[{next_bank, SLOT_IP}];
  assign load_st = mem[{next_bank, SLOT_ST}];

  a_r7_saved_ip: assert property (@(posedge clk) disable iff (!rst_n)
    save |=> mem[$past(sv_ip_addr)] == $past(save_ip));
  a_r7_saved_st: assert property (@(posedge clk) disable iff (!rst_n)
    save |=> mem[$past(sv_st_addr)] == $past(save_st));
  a_r10_port_lands_in_old: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !(save && wr_idx <= SLOT_ST) |=> mem[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/ctx_regfile.sv
module ctx_regfile
  import ctxrf_pkg::*;
#(
  parameter int NBANK = 32,
  parameter int NREG  = 16,
  parameter int DW    = 32,
  localparam int BW = $clog2(NBANK),
  localparam int IW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd0_idx,
  input  logic [IW-1:0] rd1_idx,
  output logic [DW-1:0] rd0_data,
  output logic [DW-1:0] rd1_data,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          fetch_vld,
  input  logic [DW-1:0] fetch_ip,
  input  logic          ctx_swap,
  input  logic [BW-1:0] ctx_sel,
  output logic [BW-1:0] ctx_bank,
  output logic [DW-1:0] ip_out,
  output logic [DW-1:0] status_out
);

  localparam int NRD = 2;

  logic          reload;
  logic          ip_port_hit, st_port_hit;
  logic [DW-1:0] ip_q, st_q, ip_merged, st_merged, load_ip, load_st;
  logic [DW-1:0] rd_raw [NRD];
  logic [IW-1:0] rd_idx [NRD];
  logic [DW-1:0] rd_out [NRD];

  assign ip_port_hit = wr_en && (wr_idx == IW'(0));
  assign st_port_hit = wr_en && (wr_idx == IW'(1));

  ctxrf_bank_ctl #(.NBANK(NBANK)) u_bank (
    .clk(clk), .rst_n(rst_n), .swap(ctx_swap), .sel(ctx_sel),
    .cur(ctx_bank), .reload(reload)
  );

  ctxrf_shadow #(.DW(DW)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .ip_port_hit(ip_port_hit), .st_port_hit(st_port_hit), .port_data(wr_data),
    .fetch_vld(fetch_vld), .fetch_ip(fetch_ip),
    .swap(ctx_swap), .reload(reload), .load_ip(load_ip), .load_st(load_st),
    .ip_q(ip_q), .st_q(st_q), .ip_merged(ip_merged), .st_merged(st_merged)
  );

  ctxrf_store #(.NBANK(NBANK), .NREG(NREG), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .cur(ctx_bank), .next_bank(ctx_sel),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .save(ctx_swap), .save_ip(ip_merged), .save_st(st_merged),
    .rd0_idx(rd0_idx), .rd1_idx(rd1_idx),
    .rd0_raw(rd_raw[0]), .rd1_raw(rd_raw[1]),
    .load_ip(load_ip), .load_st(load_st)
  );

  assign rd_idx[0] = rd0_idx;
  assign rd_idx[1] = rd1_idx;

  // Indices 0 and 1 are always served from the working copies.
  for (genvar p = 0; p < NRD; p++) begin : g_rdmux
    always_comb begin
      if (rd_idx[p] == IW'(0))      rd_out[p] = ip_q;
      else if (rd_idx[p] == IW'(1)) rd_out[p] = st_q;
      else                          rd_out[p] = rd_raw[p];
    end
  end

  assign rd0_data   = rd_out[0];
  assign rd1_data   = rd_out[1];
  assign ip_out     = ip_q;
  assign status_out = st_q;

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> ctx_bank == '0 && ip_out == '0 && status_out == '0);
  a_r3_ip_read_live: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld && !wr_en && !ctx_swap && rd0_idx == IW'(0)
      |=> $past(rd0_idx) != rd0_idx || rd0_data == $past(fetch_ip));

endmodule

// File: tb/tb_ctx_regfile.sv
module tb_ctx_regfile;
  localparam int NB = 32, NR = 16, DW = 32;

  logic clk = 0, rst_n = 0;
  logic [3:0] rd0_idx = 0, rd1_idx = 0, wr_idx = 0;
  logic [31:0] rd0_data, rd1_data, wr_data = 0, fetch_ip = 0, ip_out, status_out;
  logic wr_en = 0, fetch_vld = 0, ctx_swap = 0;
  logic [4:0] ctx_sel = 0, ctx_bank;

  always #10 clk = ~clk;

  ctx_regfile dut (.*);

  int vecs = 0, errs = 0;
  logic [31:0] m_mem [NB*NR];
  bit m_vld [NB*NR];
  logic [31:0] m_ip, m_st;
  bit m_ipv, m_stv;
  int m_bank;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input int idx, output bit ok);
    if (idx == 0) begin ok = m_ipv; return m_ip; end
    if (idx == 1) begin ok = m_stv; return m_st; end
    ok = m_vld[m_bank*NR+idx];
    return m_mem[m_bank*NR+idx];
  endfunction

  task automatic step(input bit we, input int wi, input logic [31:0] wd,
                      input bit fv, input logic [31:0] fip,
                      input bit sw, input int bs, input int r0, input int r1);
    bit ok;
    logic [31:0] e, nip, nst;
    bit nipv, nstv;
    wr_en = we; wr_idx = 4'(wi); wr_data = wd; fetch_vld = fv; fetch_ip = fip;
    ctx_swap = sw; ctx_sel = 5'(bs); rd0_idx = 4'(r0); rd1_idx = 4'(r1);
    #5;
    e = m_read(r0, ok); if (ok) chk(r0 < 2 ? "R3" : "R2", rd0_data, e);
    e = m_read(r1, ok); if (ok) chk(r1 < 2 ? "R3" : "R2", rd1_data, e);
    @(posedge clk);
    nip = m_ip; nst = m_st; nipv = m_ipv; nstv = m_stv;
    if (fv) begin nip = fip; nipv = 1; end
    if (we) begin
      m_mem[m_bank*NR+wi] = wd; m_vld[m_bank*NR+wi] = 1;
      if (wi == 0) begin nip = wd; nipv = 1; end
      if (wi == 1) begin nst = wd; nstv = 1; end
    end
    if (sw) begin
      m_mem[m_bank*NR] = nip;   m_vld[m_bank*NR] = nipv;
      m_mem[m_bank*NR+1] = nst; m_vld[m_bank*NR+1] = nstv;
      m_bank = bs;
      nip = m_mem[bs*NR];   nipv = m_vld[bs*NR];
      nst = m_mem[bs*NR+1]; nstv = m_vld[bs*NR+1];
    end
    m_ip = nip; m_st = nst; m_ipv = nipv; m_stv = nstv;
    @(negedge clk);
    chk("R6", 32'(ctx_bank), 32'(m_bank));
    if (m_ipv) chk(sw ? "R8" : (we && wi == 0) ? "R5" : fv ? "R4" : "R3", ip_out, m_ip);
    if (m_stv) chk(sw ? "R8" : (we && wi == 1) ? "R5" : "R11", status_out, m_st);
  endtask

  task automatic idle(input int r0, input int r1);
    step(0, 0, 0, 0, 0, 0, 0, r0, r1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    m_ip = 0; m_st = 0; m_ipv = 1; m_stv = 1; m_bank = 0;
    for (int i = 0; i < NB*NR; i++) begin m_vld[i] = 0; m_mem[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1", 32'(ctx_bank), 0);
    chk("R1", ip_out, 0);
    chk("R1", status_out, 0);

    // Fill every bank through the port.
    for (int b = 0; b < NB; b++) begin
      if (b != 0) step(0, 0, 0, 0, 0, 1, b, 2, 3);
      for (int r = 0; r < NR; r++) step(1, r, $urandom, 0, 0, 0, 0, r, 0);
    end

    // Random mix.
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 2) == 0, $urandom_range(0, 15), $urandom,
           $urandom_range(0, 1), $urandom,
           $urandom_range(0, 7) == 0, $urandom_range(0, NB-1),
           $urandom_range(0, 15), $urandom_range(0, 15));
    end

    // R7: fetch update in the swap cycle is saved with the old context.
    step(0, 0, 0, 0, 0, 1, 3, 0, 1);
    step(0, 0, 0, 1, 32'h0000_A5A0, 1, 4, 0, 1);
    step(0, 0, 0, 0, 0, 1, 3, 0, 1);
    chk("R7", ip_out, 32'h0000_A5A0);

    // R9: same-bank swap keeps the port-written IP.
    step(1, 0, 32'h1234_5678, 1, 32'h0000_0ABC, 1, 3, 2, 3);
    chk("R9", ip_out, 32'h1234_5678);
    step(1, 1, 32'h0F0F_0F0F, 0, 0, 1, 3, 2, 3);
    chk("R9", status_out, 32'h0F0F_0F0F);

    // R10: port write in the swap cycle lands in the outgoing bank.
    step(1, 7, 32'hDEAD_BEEF, 0, 0, 1, 6, 7, 7);
    step(0, 0, 0, 0, 0, 0, 0, 7, 2);
    chk("R10", rd0_data, m_mem[6*NR+7]);
    step(0, 0, 0, 0, 0, 1, 3, 0, 0);
    idle(7, 1);
    chk("R10", rd0_data, 32'hDEAD_BEEF);

    // R11: fetch never touches status; R4 covered alongside.
    step(0, 0, 0, 1, 32'h0000_7770, 0, 0, 1, 0);
    chk("R11", status_out, 32'h0F0F_0F0F);
    chk("R4", ip_out, 32'h0000_7770);

    // R5: port write to index 0 beats fetch.
    step(1, 0, 32'h5555_0000, 1, 32'h0000_9990, 0, 0, 0, 0);
    chk("R5", ip_out, 32'h5555_0000);
    idle(0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule